// File: doc/BRIEF.md
# Scoreboard Issue Controller for Single-Cycle Function Units

This block schedules a small pool of identical function units that share one register file with a single operand-read port and a single write port. An instruction offered at the issue input is handed to the lowest-numbered idle unit. That unit goes busy and waits for permission to read its operands. It executes in one cycle, asks to be released, and retires when it is granted the write port. The block tracks which registers have a write outstanding. It refuses an issue that would create a second outstanding write to the same register. It holds back a reader whose source is still being produced, and holds back a writer whose destination an older unit has yet to read.

Results leave on a shared writeback bus that carries a valid flag, the destination register and the data. Every waiting unit snoops this bus. A unit waiting on a source register may be granted the read port in the very cycle that register's value is being written. Read-port and write-port requests go through two separate lowest-index-first pickers, so each port serves at most one unit per cycle. Instruction decode, the ALU datapath and memory operations sit outside the block: ALU results come in on `fu_result`.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every unit is idle, no register has a write pending, and `iss_unit`, `rd_grant`, `rel_req`, `wr_grant` and `wb_valid` are all zero.
- R2: An offered instruction goes to the lowest-numbered idle unit, shown one-hot on `iss_unit` (bit i = unit i). When all units are busy it is refused, and `iss_accept` and `iss_unit` stay zero.
- R3: An offered instruction whose destination register already has a write pending is refused (write-after-write).
- R4: A waiting unit requests the read port only when each of its source registers had no pending write at issue, or has since appeared on the writeback bus, or is valid on the writeback bus in the current cycle.
- R5: `rd_grant` is one-hot or zero and serves the lowest-numbered requesting unit. `rd_src_a`/`rd_src_b` carry the granted unit's source registers, or zero when nothing is granted.
- R6: A unit raises `rel_req` in the cycle after its read grant and keeps it high until it receives its write grant.
- R7: `wr_grant` is one-hot or zero and serves the lowest-numbered releasing unit. In that cycle `wb_valid` is 1, `wb_reg` is the unit's destination and `wb_data` is its slice of `fu_result` (bits [i*DW +: DW]).
- R8: A unit granted the write port is idle in the next cycle, and its destination register is no longer pending, so an issue to that register is then accepted.
- R9: A releasing unit is not granted the write port while another waiting unit still needs the old value of that unit's destination register (write-after-read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_dst | input | RW | Destination register of the offered instruction |
| iss_src_a | input | RW | First source register |
| iss_src_b | input | RW | Second source register |
| fu_result | input | NFU*DW | ALU result of each unit, unit i in bits [i*DW +: DW] |
| iss_accept | output | 1 | Offered instruction taken this cycle |
| iss_unit | output | NFU | One-hot unit receiving the instruction |
| fu_busy | output | NFU | Unit holds an instruction |
| rd_grant | output | NFU | One-hot read-port grant |
| rd_src_a | output | RW | First source register of the read-granted unit |
| rd_src_b | output | RW | Second source register of the read-granted unit |
| rel_req | output | NFU | Unit has executed and asks to retire |
| wr_grant | output | NFU | One-hot write-port grant (retire) |
| wb_valid | output | 1 | Writeback bus carries a result |
| wb_reg | output | RW | Writeback destination register |
| wb_data | output | DW | Writeback result data |

## Verification
The interesting overlap is a retire of one unit in the same cycle as a read grant to another unit that waits on the retiring unit's destination. The snooped bus must release the reader in that very cycle, not one later. A directed pair of dependent instructions provokes it. Long random runs over only four registers, with issue attempted most cycles, make it recur together with issues in the same cycle as a retire. Each cycle, a bench-side cycle model of the requirements predicts the grants, the issue choice and the bus fields. Every one of them is compared at the ports.

// File: rtl/sb_pkg.sv
// Shared types for the scoreboard issue controller.
// Assumes: three states per function-unit slot are enough because each ALU
// completes in exactly one cycle.
package sb_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2
    } slot_state_e;
endpackage

// File: rtl/sb_pick.sv
// Lowest-index-first one-hot picker.
// Assumes: req may be any pattern; grant is zero when req is zero.
module sb_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Walk from bit 0 upward and keep only the first request seen.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_pend.sv
// Per-register pending-write vector.
// Assumes: set and clear never target the same register in one cycle
// (issue is refused while the destination is pending).
module sb_pend #(
    parameter int NREG = 8,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [RW-1:0]   set_reg,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_reg,
    output logic [NREG-1:0] pend_o
);
    // Mark a destination at issue, unmark it when its owner retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (set_en && set_reg == RW'(r)) begin
                    pend_o[r] <= 1'b1;
                end else if (clr_en && clr_reg == RW'(r)) begin
                    pend_o[r] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sb_fu_slot.sv
// State of one function unit: idle, waiting for the read port, executed.
// Holds the instruction's registers and one hold flag per source that marks
// a value still to be produced by an older unit.
// Assumes: hold flags are computed by the parent at issue time.
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [RW-1:0] dst_i,
    input  logic [RW-1:0] src_a_i,
    input  logic [RW-1:0] src_b_i,
    input  logic          hold_a_i,
    input  logic          hold_b_i,
    input  logic          rd_grant_i,
    input  logic          wr_grant_i,
    input  logic          wb_valid_i,
    input  logic [RW-1:0] wb_reg_i,
    output logic          busy_o,
    output logic          waiting_o,
    output logic          rd_req_o,
    output logic          rel_req_o,
    output logic [RW-1:0] dst_o,
    output logic [RW-1:0] src_a_o,
    output logic [RW-1:0] src_b_o,
    output logic          hold_a_o,
    output logic          hold_b_o
);
    slot_state_e state;
    logic        snoop_a;
    logic        snoop_b;

    // Writeback bus currently delivering each held source.
    always_comb begin
        snoop_a = wb_valid_i && (wb_reg_i == src_a_o);
        snoop_b = wb_valid_i && (wb_reg_i == src_b_o);
    end

    // Slot state and captured instruction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SLOT_IDLE;
            dst_o    <= '0;
            src_a_o  <= '0;
            src_b_o  <= '0;
            hold_a_o <= 1'b0;
            hold_b_o <= 1'b0;
        end else begin
            case (state)
                SLOT_IDLE: begin
                    if (issue_i) begin
                        state    <= SLOT_WAIT;
                        dst_o    <= dst_i;
                        src_a_o  <= src_a_i;
                        src_b_o  <= src_b_i;
                        hold_a_o <= hold_a_i;
                        hold_b_o <= hold_b_i;
                    end
                end
                SLOT_WAIT: begin
                    if (snoop_a) hold_a_o <= 1'b0;
                    if (snoop_b) hold_b_o <= 1'b0;
                    if (rd_grant_i) state <= SLOT_EXEC;
                end
                SLOT_EXEC: begin
                    if (wr_grant_i) state <= SLOT_IDLE;
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    // Status and request outputs decoded from state.
    always_comb begin
        busy_o    = (state != SLOT_IDLE);
        waiting_o = (state == SLOT_WAIT);
        rel_req_o = (state == SLOT_EXEC);
        rd_req_o  = waiting_o && (!hold_a_o || snoop_a) && (!hold_b_o || snoop_b);
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue controller for NFU single-cycle function units sharing a
// register file with one read port and one write port.
// Assumes: fu_result of a unit is valid while its rel_req is high.
module sb_issue_ctrl #(
    parameter int NFU  = 3,
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [RW-1:0]     iss_dst,
    input  logic [RW-1:0]     iss_src_a,
    input  logic [RW-1:0]     iss_src_b,
    input  logic [NFU*DW-1:0] fu_result,
    output logic              iss_accept,
    output logic [NFU-1:0]    iss_unit,
    output logic [NFU-1:0]    fu_busy,
    output logic [NFU-1:0]    rd_grant,
    output logic [RW-1:0]     rd_src_a,
    output logic [RW-1:0]     rd_src_b,
    output logic [NFU-1:0]    rel_req,
    output logic [NFU-1:0]    wr_grant,
    output logic              wb_valid,
    output logic [RW-1:0]     wb_reg,
    output logic [DW-1:0]     wb_data
);
    logic [NREG-1:0] pend_vec;
    logic [NFU-1:0]  waiting;
    logic [NFU-1:0]  rd_req;
    logic [NFU-1:0]  wr_req;
    logic [NFU-1:0]  idle_pick;
    logic [RW-1:0]   slot_dst   [NFU];
    logic [RW-1:0]   slot_src_a [NFU];
    logic [RW-1:0]   slot_src_b [NFU];
    logic [NFU-1:0]  slot_hold_a;
    logic [NFU-1:0]  slot_hold_b;
    logic            new_hold_a;
    logic            new_hold_b;

    // Issue decision: an idle unit exists and the destination is free.
    always_comb begin
        iss_accept = iss_valid && !(&fu_busy) && !pend_vec[iss_dst];
        iss_unit   = iss_accept ? idle_pick : '0;
        new_hold_a = pend_vec[iss_src_a] && !(wb_valid && wb_reg == iss_src_a);
        new_hold_b = pend_vec[iss_src_b] && !(wb_valid && wb_reg == iss_src_b);
    end

    sb_pick #(.N(NFU)) u_idle_pick (
        .req   (~fu_busy),
        .grant (idle_pick)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NFU; gi++) begin : g_slot
            sb_fu_slot #(.RW(RW)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .issue_i    (iss_unit[gi]),
                .dst_i      (iss_dst),
                .src_a_i    (iss_src_a),
                .src_b_i    (iss_src_b),
                .hold_a_i   (new_hold_a),
                .hold_b_i   (new_hold_b),
                .rd_grant_i (rd_grant[gi]),
                .wr_grant_i (wr_grant[gi]),
                .wb_valid_i (wb_valid),
                .wb_reg_i   (wb_reg),
                .busy_o     (fu_busy[gi]),
                .waiting_o  (waiting[gi]),
                .rd_req_o   (rd_req[gi]),
                .rel_req_o  (rel_req[gi]),
                .dst_o      (slot_dst[gi]),
                .src_a_o    (slot_src_a[gi]),
                .src_b_o    (slot_src_b[gi]),
                .hold_a_o   (slot_hold_a[gi]),
                .hold_b_o   (slot_hold_b[gi])
            );
        end
    endgenerate

    // Write requests, withheld while an older waiting reader needs the old value.
    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            wr_req[u] = rel_req[u];
            for (int v = 0; v < NFU; v++) begin
                if (waiting[v] &&
                    ((slot_src_a[v] == slot_dst[u] && !slot_hold_a[v]) ||
                     (slot_src_b[v] == slot_dst[u] && !slot_hold_b[v]))) begin
                    wr_req[u] = 1'b0;
                end
            end
        end
    end

    sb_pick #(.N(NFU)) u_wr_pick (
        .req   (wr_req),
        .grant (wr_grant)
    );

    sb_pick #(.N(NFU)) u_rd_pick (
        .req   (rd_req),
        .grant (rd_grant)
    );

    // Drive the writeback bus and read-port addresses from the granted units.
    always_comb begin
        wb_valid = |wr_grant;
        wb_reg   = '0;
        wb_data  = '0;
        rd_src_a = '0;
        rd_src_b = '0;
        for (int u = 0; u < NFU; u++) begin
            if (wr_grant[u]) begin
                wb_reg  = slot_dst[u];
                wb_data = fu_result[u*DW +: DW];
            end
            if (rd_grant[u]) begin
                rd_src_a = slot_src_a[u];
                rd_src_b = slot_src_b[u];
            end
        end
    end

    sb_pend #(.NREG(NREG)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (iss_accept),
        .set_reg (iss_dst),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .pend_o  (pend_vec)
    );
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
// Property checker for the scoreboard issue controller, bound to every instance.
module sb_issue_ctrl_chk #(
    parameter int NFU  = 3,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_accept,
    input logic [RW-1:0]   iss_dst,
    input logic [NFU-1:0]  iss_unit,
    input logic [NFU-1:0]  fu_busy,
    input logic [NFU-1:0]  rd_grant,
    input logic [NFU-1:0]  rel_req,
    input logic [NFU-1:0]  wr_grant,
    input logic            wb_valid,
    input logic [RW-1:0]   wb_reg,
    input logic [NREG-1:0] pend_vec
);
    assert_rd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_grant));

    assert_wr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    assert_issue_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> ($onehot(iss_unit) && ((iss_unit & fu_busy) == '0)));

    assert_no_waw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> !pend_vec[iss_dst]);

    assert_retire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !pend_vec[$past(wb_reg)]);

    genvar gi;
    generate
        for (gi = 0; gi < NFU; gi++) begin : g_unit
            assert_rel_after_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rd_grant[gi] |=> rel_req[gi]);
            assert_rel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (rel_req[gi] && !wr_grant[gi]) |=> rel_req[gi]);
            assert_idle_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wr_grant[gi] |=> !fu_busy[gi]);
        end
    endgenerate
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NFU(NFU), .NREG(NREG)) u_chk (.*);

// File: tb/sb_issue_ctrl_bench.sv
`timescale 1ns/1ps
module sb_issue_ctrl_bench;
    localparam int NFU  = 3;
    localparam int NREG = 8;
    localparam int DW   = 16;
    localparam int RW   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [RW-1:0]     iss_dst = '0;
    logic [RW-1:0]     iss_src_a = '0;
    logic [RW-1:0]     iss_src_b = '0;
    logic [NFU*DW-1:0] fu_result = '0;
    logic              iss_accept;
    logic [NFU-1:0]    iss_unit;
    logic [NFU-1:0]    fu_busy;
    logic [NFU-1:0]    rd_grant;
    logic [RW-1:0]     rd_src_a;
    logic [RW-1:0]     rd_src_b;
    logic [NFU-1:0]    rel_req;
    logic [NFU-1:0]    wr_grant;
    logic              wb_valid;
    logic [RW-1:0]     wb_reg;
    logic [DW-1:0]     wb_data;

    int checks = 0;
    int failures = 0;

    // Bench model of the requirements: per-unit state 0 idle, 1 waiting, 2 executed.
    int            m_st  [NFU];
    logic [RW-1:0] m_dst [NFU];
    logic [RW-1:0] m_sa  [NFU];
    logic [RW-1:0] m_sb  [NFU];
    logic          m_ha  [NFU];
    logic          m_hb  [NFU];
    logic [NREG-1:0] m_pend;

    always #2.5 clk = ~clk;

    sb_issue_ctrl #(.NFU(NFU), .NREG(NREG), .DW(DW)) u_sb_issue_ctrl (.*);

    function automatic logic [NFU-1:0] lowest(input logic [NFU-1:0] v);
        for (int i = 0; i < NFU; i++) if (v[i]) return NFU'(1) << i;
        return '0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NFU; i++) begin
            m_st[i] = 0; m_dst[i] = '0; m_sa[i] = '0; m_sb[i] = '0;
            m_ha[i] = 1'b0; m_hb[i] = 1'b0;
        end
        m_pend = '0;
    endtask

    // One cycle: drive inputs, predict and compare outputs, advance the model.
    task automatic step(input logic v, input logic [RW-1:0] d, input logic [RW-1:0] a, input logic [RW-1:0] b);
        logic [NFU-1:0] wrq, wrg, rdq, rdg, idl, iu;
        logic           wbv;
        logic [RW-1:0]  wbr, ra, rb;
        logic [DW-1:0]  wbd;
        iss_valid = v; iss_dst = d; iss_src_a = a; iss_src_b = b;
        fu_result = {$urandom, $urandom};
        #1;
        for (int u = 0; u < NFU; u++) begin
            wrq[u] = (m_st[u] == 2);
            for (int w = 0; w < NFU; w++)
                if (m_st[w] == 1 && ((m_sa[w] == m_dst[u] && !m_ha[w]) ||
                                     (m_sb[w] == m_dst[u] && !m_hb[w]))) wrq[u] = 1'b0;
        end
        wrg = lowest(wrq);
        wbv = |wrg; wbr = '0; wbd = '0;
        for (int u = 0; u < NFU; u++) if (wrg[u]) begin wbr = m_dst[u]; wbd = fu_result[u*DW +: DW]; end
        for (int u = 0; u < NFU; u++)
            rdq[u] = (m_st[u] == 1) && (!m_ha[u] || (wbv && wbr == m_sa[u]))
                                    && (!m_hb[u] || (wbv && wbr == m_sb[u]));
        rdg = lowest(rdq);
        ra = '0; rb = '0;
        for (int u = 0; u < NFU; u++) if (rdg[u]) begin ra = m_sa[u]; rb = m_sb[u]; end
        for (int u = 0; u < NFU; u++) idl[u] = (m_st[u] == 0);
        iu = (v && !m_pend[d] && |idl) ? lowest(idl) : '0;

        chk("R2/R3", "iss_unit", 32'(iss_unit), 32'(iu));
        chk("R2/R3", "iss_accept", 32'(iss_accept), 32'(|iu));
        chk("R4/R5", "rd_grant", 32'(rd_grant), 32'(rdg));
        chk("R5", "rd_src", {rd_src_a, rd_src_b}, {ra, rb});
        chk("R7/R9", "wr_grant", 32'(wr_grant), 32'(wrg));
        chk("R7", "wb_bus", {wb_valid, wb_reg, wb_data}, {wbv, wbr, wbd});
        for (int u = 0; u < NFU; u++) begin
            chk("R6", "rel_req", 32'(rel_req[u]), 32'(m_st[u] == 2));
            chk("R8", "fu_busy", 32'(fu_busy[u]), 32'(m_st[u] != 0));
        end

        @(posedge clk);
        for (int u = 0; u < NFU; u++) begin
            if (wrg[u]) begin m_st[u] = 0; m_pend[m_dst[u]] = 1'b0; end
            else if (rdg[u]) m_st[u] = 2;
            else if (m_st[u] == 1) begin
                if (wbv && wbr == m_sa[u]) m_ha[u] = 1'b0;
                if (wbv && wbr == m_sb[u]) m_hb[u] = 1'b0;
            end
        end
        for (int u = 0; u < NFU; u++) if (iu[u]) begin
            m_st[u] = 1; m_dst[u] = d; m_sa[u] = a; m_sb[u] = b;
            m_ha[u] = m_pend[a] && !(wbv && wbr == a);
            m_hb[u] = m_pend[b] && !(wbv && wbr == b);
        end
        for (int u = 0; u < NFU; u++) if (iu[u]) m_pend[d] = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports.
        #1;
        chk("R1", "fu_busy", 32'(fu_busy), 0);
        chk("R1", "grants", {rd_grant, wr_grant, rel_req, iss_unit}, 0);
        chk("R1", "wb_valid", 32'(wb_valid), 0);
        @(negedge clk);

        // R4: dependent reader released by snooping the retiring writer.
        step(1, 3'd1, 3'd2, 3'd3);
        step(1, 3'd4, 3'd1, 3'd1);
        repeat (5) step(0, 0, 0, 0);
        // R3: second write to a pending register refused; R8: accepted after retire.
        step(1, 3'd5, 3'd0, 3'd0);
        step(1, 3'd5, 3'd0, 3'd0);
        chk("R3", "pending_refused_busy", 32'(fu_busy), 32'b001);
        repeat (4) step(0, 0, 0, 0);
        step(1, 3'd5, 3'd0, 3'd0);
        repeat (4) step(0, 0, 0, 0);
        // R9: older reader of r2 waits on r1; younger writer of r2 must hold.
        step(1, 3'd1, 3'd0, 3'd0);
        step(1, 3'd3, 3'd1, 3'd2);
        step(1, 3'd2, 3'd0, 3'd0);
        repeat (6) step(0, 0, 0, 0);

        // Random phases: narrow register set for dense hazards, then wide.
        for (int n = 0; n < 4000; n++)
            step(($urandom % 10) < 8, RW'($urandom % 4), RW'($urandom % 4), RW'($urandom % 4));
        for (int n = 0; n < 3000; n++)
            step(($urandom % 10) < 6, RW'($urandom), RW'($urandom), RW'($urandom));
        repeat (10) step(0, 0, 0, 0);
        chk("R8", "drained", 32'(fu_busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule